// File: doc/BRIEF.md
# Hot-Plug Slot Control State with Split Reset Domains

This block keeps the hot-plug slot control fields and the matching capability bits for one downstream switch port. It also decides what each of them does when a reset arrives. There are two reset domains. The global switch reset is asserted asynchronously and released synchronously. It returns everything to hard-wired values. Four single-cycle partition reset strobes are the partition fundamental reset, the partition hot reset, the upstream secondary bus reset and the downstream secondary bus reset. These strobes reload only the control fields, taking each one from a per-port initial-value input. The capability bits and the slot-implemented bit are sticky: they ignore every partition reset.

The slot power-enable pin is a register loaded from the next value of the power control field. The pin therefore changes only when that field really changes. If a partition reset writes back the value the field already holds, the pin does not move. A presence-change status bit is driven by a two-state machine with the states ARMED and MASKED. A hot reset or either secondary bus reset moves it from ARMED to MASKED, because the link passes through hot reset and retrains from Detect. While it is MASKED, presence edges are ignored. A pulse on `link_retrained` moves it from MASKED back to ARMED. A partition fundamental reset moves it to ARMED. A global reset also sets ARMED.

Each control field is one bit, and field i is gated by capability bit i. The fields are: bit 0, power control (1 = slot power off); bit 1, attention indicator; bit 2, power indicator; bit 3, interlock. Capability write bit NFLD (bit 4 by default) carries the slot-implemented bit.

Top module: `hp_slot_rst_ctl`

## Requirements
- R1: While the global reset is held, and after it is released, all control fields are 0 and every capability bit reads 1. `slot_impl` is 1, `pres_chg` is 0 and `pwr_en` is 1.
- R2: A write with `ctl_wr_en` high loads each enabled field from `ctl_wr_data`. The new value appears on `slot_ctl` after the next clock edge.
- R3: A field whose capability bit is 0 reads 0. It ignores both writes and partition reloads. A capability write that clears bit i forces field i to 0 on the same edge.
- R4: Any partition reset strobe loads each enabled field from `init_val` on that edge. A same-cycle software write is overridden.
- R5: Only `cap_wr_en` or the global reset changes `cap_bits` and `slot_impl`. No partition reset strobe changes them.
- R6: `pwr_en` is 1 exactly when field bit 0 is 0, and it is updated on the same edge as the field. Across a partition reset it toggles at most once. It does not toggle at all when the old value and the reloaded value are equal.
- R7: In state ARMED, a change on `presence` sets `pres_chg` on the next edge. A `pres_chg_w1c` pulse clears it. If both happen in the same cycle, the set wins.
- R8: The hot reset and both secondary bus resets move ARMED to MASKED. No presence edge then sets `pres_chg`, including an edge in the strobe cycle itself. A `link_retrained` pulse moves MASKED back to ARMED.
- R9: A partition fundamental reset clears `pres_chg` and leaves the state machine in ARMED. After it, presence changes are reported again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sw_rst_n | input | 1 | Global switch reset, active low, asynchronous assert |
| prt_fund | input | 1 | Partition fundamental reset strobe |
| prt_hot | input | 1 | Partition hot reset strobe |
| prt_usbr | input | 1 | Upstream secondary bus reset strobe |
| prt_dsbr | input | 1 | Downstream secondary bus reset strobe |
| ctl_wr_en | input | 1 | Software write of the control fields |
| ctl_wr_data | input | NFLD | Control field write data |
| cap_wr_en | input | 1 | Write of the capability bits and the slot-implemented bit |
| cap_wr_data | input | NFLD+1 | Capability bits; the top bit is slot-implemented |
| init_val | input | NFLD | Initial values for partition reloads |
| presence | input | 1 | Presence detect level |
| link_retrained | input | 1 | Pulse when the link has retrained after hot reset |
| pres_chg_w1c | input | 1 | Write-one-to-clear of the presence-change bit |
| slot_ctl | output | NFLD | Current control fields |
| cap_bits | output | NFLD | Sticky capability bits |
| slot_impl | output | 1 | Sticky slot-implemented bit |
| pwr_en | output | 1 | Slot power-enable pin |
| pres_chg | output | 1 | Presence-change status bit |

## Verification
A capability bit that the wrong reset domain clears shows up on `cap_bits`, or as a zeroed field, one edge after the offending strobe. A reload that uses the wrong source, or loses to a same-cycle write, is visible on `slot_ctl` one edge later. A glitch or an extra transition on `pwr_en` is caught by counting every edge of the pin across the reset window. A state machine stuck in MASKED or ARMED shows as a missing or spurious `pres_chg` one edge after a presence edge.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    typedef enum logic {
        PD_ARMED  = 1'b0,
        PD_MASKED = 1'b1
    } pd_state_e;

    localparam int unsigned FLD_PWR = 0;
endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] sync_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end

    assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/hp_ctl_field.sv
module hp_ctl_field #(
    parameter bit CAP_RST = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_wr,
    input  logic cap_d,
    input  logic ctl_wr,
    input  logic ctl_d,
    input  logic part_rst,
    input  logic init_d,
    output logic cap_q,
    output logic ctl_q,
    output logic ctl_nxt
);
    logic cap_nxt;

    assign cap_nxt = cap_wr ? cap_d : cap_q;

    always_comb begin
        if (!cap_nxt)      ctl_nxt = 1'b0;
        else if (part_rst) ctl_nxt = init_d;
        else if (ctl_wr)   ctl_nxt = ctl_d;
        else               ctl_nxt = ctl_q;
    end

    // sticky: only the global reset touches it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= CAP_RST;
        else        cap_q <= cap_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= 1'b0;
        else        ctl_q <= ctl_nxt;
    end

    AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_q |-> !ctl_q); // R3
    AST_RELOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (part_rst && !cap_wr && cap_q) |=> (ctl_q == $past(init_d))); // R4
    AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (part_rst && !cap_wr) |=> $stable(cap_q)); // R5
endmodule

// File: rtl/hp_pdc_fsm.sv
module hp_pdc_fsm
    import hp_slot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fund_rst,
    input  logic mask_start,
    input  logic retrained,
    input  logic presence,
    input  logic w1c,
    output logic pdc
);
    pd_state_e st_q, st_nxt;
    logic      pres_q;
    logic      edge_seen;
    logic      pdc_set;

    assign edge_seen = presence ^ pres_q;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            PD_ARMED: begin
                if (mask_start) st_nxt = PD_MASKED;
            end
            PD_MASKED: begin
                if (mask_start)     st_nxt = PD_MASKED;
                else if (retrained) st_nxt = PD_ARMED;
                else if (fund_rst)  st_nxt = PD_ARMED;
            end
            default: st_nxt = PD_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PD_ARMED;
        else        st_q <= st_nxt;
    end

    // output process
    always_comb begin
        pdc_set = 1'b0;
        unique case (st_q)
            PD_ARMED:  pdc_set = edge_seen && !mask_start && !fund_rst;
            PD_MASKED: pdc_set = 1'b0;
            default:   pdc_set = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_q <= 1'b0;
            pdc    <= 1'b0;
        end else begin
            pres_q <= presence;
            if (fund_rst)     pdc <= 1'b0;
            else if (pdc_set) pdc <= 1'b1;
            else if (w1c)     pdc <= 1'b0;
        end
    end

    AST_NO_PDC_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PD_MASKED) |=> !$rose(pdc)); // R8
    AST_MASK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        mask_start |=> (st_q == PD_MASKED)); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PD_ARMED && edge_seen && !mask_start && !fund_rst) |=> pdc); // R7
    AST_FUND_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        fund_rst |=> !pdc); // R9
endmodule

// File: rtl/hp_slot_rst_ctl.sv
module hp_slot_rst_ctl
    import hp_slot_pkg::*;
#(
    parameter int unsigned     NFLD     = 4,
    parameter logic [NFLD-1:0] CAP_RST  = '1,
    parameter bit              SLOT_RST = 1'b1
) (
    input  logic            clk,
    input  logic            sw_rst_n,
    input  logic            prt_fund,
    input  logic            prt_hot,
    input  logic            prt_usbr,
    input  logic            prt_dsbr,
    input  logic            ctl_wr_en,
    input  logic [NFLD-1:0] ctl_wr_data,
    input  logic            cap_wr_en,
    input  logic [NFLD:0]   cap_wr_data,
    input  logic [NFLD-1:0] init_val,
    input  logic            presence,
    input  logic            link_retrained,
    input  logic            pres_chg_w1c,
    output logic [NFLD-1:0] slot_ctl,
    output logic [NFLD-1:0] cap_bits,
    output logic            slot_impl,
    output logic            pwr_en,
    output logic            pres_chg
);
    localparam int unsigned SLOT_BIT = NFLD;

    logic            rst_n;
    logic            part_any;
    logic            retrain_rst;
    logic [NFLD-1:0] ctl_nxt;

    assign part_any    = prt_fund | prt_hot | prt_usbr | prt_dsbr;
    assign retrain_rst = prt_hot | prt_usbr | prt_dsbr;

    hp_rst_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .arst_n (sw_rst_n),
        .srst_n (rst_n)
    );

    for (genvar i = 0; i < NFLD; i++) begin : g_fld
        hp_ctl_field #(.CAP_RST(CAP_RST[i])) u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .cap_wr   (cap_wr_en),
            .cap_d    (cap_wr_data[i]),
            .ctl_wr   (ctl_wr_en),
            .ctl_d    (ctl_wr_data[i]),
            .part_rst (part_any),
            .init_d   (init_val[i]),
            .cap_q    (cap_bits[i]),
            .ctl_q    (slot_ctl[i]),
            .ctl_nxt  (ctl_nxt[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         slot_impl <= SLOT_RST;
        else if (cap_wr_en) slot_impl <= cap_wr_data[SLOT_BIT];
    end

    // pin is a flop fed by the field's next value: it moves only on a real change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwr_en <= 1'b1;
        else        pwr_en <= !ctl_nxt[FLD_PWR];
    end

    hp_pdc_fsm u_pdc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fund_rst   (prt_fund),
        .mask_start (retrain_rst),
        .retrained  (link_retrained),
        .presence   (presence),
        .w1c        (pres_chg_w1c),
        .pdc        (pres_chg)
    );

    AST_PWR_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en == !slot_ctl[FLD_PWR]); // R6
    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (part_any && !cap_wr_en && !slot_ctl[FLD_PWR] && !init_val[FLD_PWR])
        |=> (pwr_en && $past(pwr_en))); // R6
    AST_SLOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (part_any && !cap_wr_en) |=> $stable(slot_impl)); // R5
endmodule

// File: tb/tb_hp_slot_rst_ctl.sv
module tb_hp_slot_rst_ctl;
    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          sw_rst_n = 1'b0;
    logic          prt_fund = 0, prt_hot = 0, prt_usbr = 0, prt_dsbr = 0;
    logic          ctl_wr_en = 0, cap_wr_en = 0;
    logic [NF-1:0] ctl_wr_data = '0, init_val = '0;
    logic [NF:0]   cap_wr_data = '0;
    logic          presence = 0, link_retrained = 0, pres_chg_w1c = 0;
    logic [NF-1:0] slot_ctl, cap_bits;
    logic          slot_impl, pwr_en, pres_chg;

    int nchk = 0, nfail = 0, toggles = 0;
    bit win = 0, done = 0;

    always #4 clk = ~clk;

    hp_slot_rst_ctl #(.NFLD(NF)) dut (
        .clk(clk), .sw_rst_n(sw_rst_n),
        .prt_fund(prt_fund), .prt_hot(prt_hot), .prt_usbr(prt_usbr), .prt_dsbr(prt_dsbr),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .cap_wr_en(cap_wr_en), .cap_wr_data(cap_wr_data),
        .init_val(init_val), .presence(presence),
        .link_retrained(link_retrained), .pres_chg_w1c(pres_chg_w1c),
        .slot_ctl(slot_ctl), .cap_bits(cap_bits), .slot_impl(slot_impl),
        .pwr_en(pwr_en), .pres_chg(pres_chg)
    );

    always @(pwr_en) if (win) toggles++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    task automatic glob_reset();
        @(negedge clk); sw_rst_n = 1'b0;
        @(negedge clk);
        chk("R1 ctl in reset", slot_ctl, 0);
        chk("R1 pwr in reset", pwr_en, 1);
        sw_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 ctl", slot_ctl, 0);
        chk("R1 cap", cap_bits, 4'hF);
        chk("R1 slot", slot_impl, 1);
        chk("R1 pdc", pres_chg, 0);
        chk("R1 pwr", pwr_en, 1);
    endtask

    task automatic pulse_retrain();
        @(negedge clk); link_retrained = 1;
        @(negedge clk); link_retrained = 0;
    endtask

    task automatic toggle_pres(input string req, input logic exp);
        @(negedge clk); presence = ~presence;
        @(negedge clk);
        chk(req, pres_chg, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        glob_reset();

        // sweep: reset type x capability x prior value x initial value
        for (int t = 0; t < 4; t++)
            for (int c = 0; c < 16; c++)
                for (int p = 0; p < 16; p++)
                    for (int iv = 0; iv < 16; iv++) begin
                        logic [NF-1:0] old_v, new_v;
                        old_v = p[NF-1:0] & c[NF-1:0];
                        new_v = iv[NF-1:0] & c[NF-1:0];
                        @(negedge clk);
                        cap_wr_en = 1; cap_wr_data = {1'b1, c[NF-1:0]};
                        ctl_wr_en = 1; ctl_wr_data = p[NF-1:0];
                        @(negedge clk);
                        chk("R2 R3 write", slot_ctl, old_v);
                        chk("R6 pwr before", pwr_en, !old_v[0]);
                        cap_wr_en = 0;
                        ctl_wr_data = ~iv[NF-1:0];   // write in reset cycle must lose
                        init_val = iv[NF-1:0];
                        {prt_dsbr, prt_usbr, prt_hot, prt_fund} = 4'b0001 << t;
                        toggles = 0; win = 1;
                        @(negedge clk);
                        {prt_dsbr, prt_usbr, prt_hot, prt_fund} = 4'b0000;
                        ctl_wr_en = 0; win = 0;
                        chk("R4 reload", slot_ctl, new_v);
                        chk("R5 cap sticky", cap_bits, c);
                        chk("R5 slot sticky", slot_impl, 1);
                        chk("R6 pwr after", pwr_en, !new_v[0]);
                        chk("R6 toggles", toggles, (old_v[0] != new_v[0]) ? 1 : 0);
                    end

        // slot-implemented cleared survives a partition reset, returns on global reset
        @(negedge clk); cap_wr_en = 1; cap_wr_data = 5'b0_1111;
        @(negedge clk); cap_wr_en = 0; prt_fund = 1;
        @(negedge clk); prt_fund = 0;
        chk("R5 slot0 sticky", slot_impl, 0);
        @(negedge clk); cap_wr_en = 1; cap_wr_data = 5'b0_0000;
        @(negedge clk); cap_wr_en = 0;
        chk("R3 cap clear", cap_bits, 0);
        glob_reset();

        // presence-change status
        presence = 0;
        pulse_retrain();
        toggle_pres("R7 set", 1);
        @(negedge clk); pres_chg_w1c = 1;
        @(negedge clk); pres_chg_w1c = 0;
        chk("R7 w1c", pres_chg, 0);
        @(negedge clk); presence = ~presence; pres_chg_w1c = 1;
        @(negedge clk); pres_chg_w1c = 0;
        chk("R7 set wins", pres_chg, 1);
        @(negedge clk); pres_chg_w1c = 1;
        @(negedge clk); pres_chg_w1c = 0;

        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            {prt_dsbr, prt_usbr, prt_hot} = 3'b001 << k;
            presence = ~presence;           // edge in strobe cycle
            @(negedge clk);
            {prt_dsbr, prt_usbr, prt_hot} = 3'b000;
            chk("R8 strobe cycle", pres_chg, 0);
            toggle_pres("R8 masked", 0);
            toggle_pres("R8 masked again", 0);
            pulse_retrain();
            toggle_pres("R8 rearmed", 1);
            @(negedge clk); pres_chg_w1c = 1;
            @(negedge clk); pres_chg_w1c = 0;
        end

        toggle_pres("R7 set before fund", 1);
        @(negedge clk); prt_fund = 1;
        @(negedge clk); prt_fund = 0;
        chk("R9 fund clears", pres_chg, 0);
        toggle_pres("R9 armed after fund", 1);

        done = 1;
        summary();
        $finish;
    end
endmodule